// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the device side of a 16-bit parallel NOR flash. It watches the write cycles that the bus front end has already latched. Each write cycle is one address and one data word. The block recognises the protected multi-cycle command sequences. When a sequence completes, it issues a single registered command pulse. The pulse carries an operation code, a target address and, for a program, the data word. Array control, erase and program timers, and status polling consume that pulse.

Every sequence starts with two unlock writes. A third write selects the operation. Program takes one more write, which holds the target. Erase repeats the two unlock writes and then a sixth write selects chip, sector or block. Three things make the decoder refuse a command: a write that does not match the expected step, an internal operation that is still busy, and a low write-protect input when the target is the boot block. In each case no pulse is issued. A sector or block erase that is running can be suspended, and then resumed, with single-write commands. While the erase is suspended, the region that was being erased cannot be programmed.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, cmd_valid_o is 0, cmd_op_o is 0, cmd_addr_o and cmd_data_o are 0, mode_o is 0 (read), and the sequence state is idle.
- R2: During command steps, only address bits 14:0 and data bits 7:0 are compared. Address bits above 14 and data bits 15:8 do not affect matching. The unlock writes are (5555h, AAh) and then (2AAAh, 55h).
- R3: The writes unlock, unlock, (5555h, A0h), and then any (A, D) raise cmd_valid_o for exactly one clock, in the cycle after the last write. The pulse carries op 1 (program), address A and data D.
- R4: The erase prefix is unlock, unlock, (5555h, 80h), unlock, unlock. A sixth write then selects the operation:
  - (5555h, 10h) gives op 4 (chip) with address 0.
  - data 30h at any address A gives op 2 (sector) with A bits 10:0 cleared.
  - data 50h at any address A gives op 3 (block) with A bits 14:0 cleared.
  - Erase pulses carry data 0.
- R5: Third-step codes at 5555h enter modes and each emits one pulse with address 0:
  - 90h gives op 5 and mode_o 1.
  - 98h gives op 6 and mode_o 2.
  - 88h gives op 7 and mode_o 3.
  - F0h, sent either as a third-step code or as a single write to any address, gives op 8 and sets mode_o to 0.
- R6: A write that does not match the expected step ends the sequence with no pulse. A later completion then needs the whole sequence again from the first unlock.
- R7: While busy_i is 1, writes produce no pulse, change no mode and leave the sequence step unchanged. Exit writes are included. The only exception is given in R8.
- R8: Suspend and resume work as follows:
  - A single write with data B0h while busy_i is 1 emits op 9 (suspend), but only if the last program or erase issued was a sector or block erase that is not already suspended.
  - Once suspended, a single write with data 30h while busy_i is 0 emits op 10 (resume).
  - B0h in any other situation is ignored.
- R9: While an erase is suspended, a program aimed at the suspended sector (bits 20:11 equal) or block (bits 20:15 equal) is ignored, and any erase sequence is ignored. A program elsewhere is accepted.
- R10: While wp_ni is 0, the following are ignored:
  - program, sector erase and block erase whose address lies in the bottom boot block (bits 20:15 all 0; all 1 when BOOT_TOP=1);
  - every chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One latched write cycle is present |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | 16 | Data word of the write |
| busy_i | input | 1 | Internal program or erase in progress |
| wp_ni | input | 1 | Write protect, active low |
| cmd_valid_o | output | 1 | One-clock command pulse |
| cmd_op_o | output | 4 | Operation code of the pulse |
| cmd_addr_o | output | ADDR_W | Target address (aligned for erase) |
| cmd_data_o | output | 16 | Program data, 0 otherwise |
| mode_o | output | 2 | Read mode 0, ID 1, query 2, security ID 3 |

## Verification
A wrong sequence step would not appear at the ports when it happens. It shows only on a later write. Either a completing write produces no pulse, or a pulse appears after an aborted or ignored sequence. For this reason the bench follows every partial or aborted sequence with the write that would complete it.

A wrong suspend or protect decision shows in the cycle after the deciding write, as a missing or extra pulse. A wrong mode register shows on mode_o at that same edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_PROG   = 4'd1,
    OP_SEC    = 4'd2,
    OP_BLK    = 4'd3,
    OP_CHIP   = 4'd4,
    OP_ID     = 4'd5,
    OP_QUERY  = 4'd6,
    OP_SECID  = 4'd7,
    OP_EXIT   = 4'd8,
    OP_SUSP   = 4'd9,
    OP_RESUME = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_ID    = 2'd1,
    MODE_QUERY = 2'd2,
    MODE_SECID = 2'd3
  } mode_e;

  localparam int KEY_AW = 15;
  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;

  typedef struct packed {
    logic at_a;
    logic at_b;
    logic aa;
    logic k55;
    logic a0;
    logic e80;
    logic c10;
    logic c30;
    logic c50;
    logic c90;
    logic c98;
    logic c88;
    logic f0;
    logic b0;
  } hit_t;
endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [KEY_AW-1:0] key_addr_i,
  input  logic [7:0]        key_data_i,
  output hit_t              hit_o
);
  always_comb begin
    hit_o.at_a = (key_addr_i == KEY_ADDR_A);
    hit_o.at_b = (key_addr_i == KEY_ADDR_B);
    hit_o.aa   = (key_data_i == 8'hAA);
    hit_o.k55  = (key_data_i == 8'h55);
    hit_o.a0   = (key_data_i == 8'hA0);
    hit_o.e80  = (key_data_i == 8'h80);
    hit_o.c10  = (key_data_i == 8'h10);
    hit_o.c30  = (key_data_i == 8'h30);
    hit_o.c50  = (key_data_i == 8'h50);
    hit_o.c90  = (key_data_i == 8'h90);
    hit_o.c98  = (key_data_i == 8'h98);
    hit_o.c88  = (key_data_i == 8'h88);
    hit_o.f0   = (key_data_i == 8'hF0);
    hit_o.b0   = (key_data_i == 8'hB0);
  end
endmodule

// File: rtl/flash_boot_guard.sv
module flash_boot_guard #(
  parameter int ADDR_W   = 21,
  parameter int BLK_LSB  = 15,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic [ADDR_W-1:BLK_LSB] blk_hi_i,
  input  logic                    wp_ni,
  output logic                    locked_o
);
  logic in_boot;

  generate
    if (BOOT_TOP) begin : g_top
      assign in_boot = &blk_hi_i;
    end else begin : g_bottom
      assign in_boot = ~|blk_hi_i;
    end
  endgenerate

  assign locked_o = in_boot & ~wp_ni;
endmodule

// File: rtl/flash_erase_susp.sv
module flash_erase_susp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fire_i,
  input  op_e                     op_i,
  input  logic [ADDR_W-1:SEC_LSB] ev_hi_i,
  input  logic [ADDR_W-1:SEC_LSB] probe_hi_i,
  output logic                    erase_run_o,
  output logic                    suspended_o,
  output logic                    in_region_o
);
  logic [ADDR_W-1:SEC_LSB] region_q;
  logic                    region_blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_run_o  <= 1'b0;
      suspended_o  <= 1'b0;
      region_q     <= '0;
      region_blk_q <= 1'b0;
    end else if (fire_i) begin
      unique case (op_i)
        OP_SEC, OP_BLK: begin
          erase_run_o  <= 1'b1;
          region_q     <= ev_hi_i;
          region_blk_q <= (op_i == OP_BLK);
        end
        OP_PROG:   if (!suspended_o) erase_run_o <= 1'b0;
        OP_CHIP:   erase_run_o <= 1'b0;
        OP_SUSP:   suspended_o <= 1'b1;
        OP_RESUME: suspended_o <= 1'b0;
        default:   ;
      endcase
    end
  end

  assign in_region_o = region_blk_q
    ? (probe_hi_i[ADDR_W-1:BLK_LSB] == region_q[ADDR_W-1:BLK_LSB])
    : (probe_hi_i == region_q);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  input  hit_t              hit_i,
  input  logic              locked_i,
  input  logic              erase_run_i,
  input  logic              suspended_i,
  input  logic              in_region_i,
  output logic              fire_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] taddr_o,
  output logic [15:0]       tdata_o
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E3, S_E4, S_E5} state_e;

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] sec_addr, blk_addr;

  assign sec_addr = {addr_i[ADDR_W-1:SEC_LSB], {SEC_LSB{1'b0}}};
  assign blk_addr = {addr_i[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    op_o    = OP_NONE;
    taddr_o = '0;
    tdata_o = '0;
    if (wr_valid_i) begin
      if (busy_i) begin
        // only suspend is heard while an operation runs
        if (hit_i.b0 && erase_run_i && !suspended_i) begin
          fire_o = 1'b1;
          op_o   = OP_SUSP;
        end
      end else begin
        state_d = S_IDLE;
        case (state_q)
          S_IDLE: begin
            if (hit_i.at_a && hit_i.aa) state_d = S_U1;
            else if (hit_i.f0) begin
              fire_o = 1'b1;
              op_o   = OP_EXIT;
            end else if (hit_i.c30 && suspended_i) begin
              fire_o = 1'b1;
              op_o   = OP_RESUME;
            end
          end
          S_U1: if (hit_i.at_b && hit_i.k55) state_d = S_U2;
          S_U2: begin
            if (hit_i.at_a) begin
              if (hit_i.a0) state_d = S_PROG;
              else if (hit_i.e80 && !suspended_i) state_d = S_E3;
              else if (hit_i.c90) begin fire_o = 1'b1; op_o = OP_ID;    end
              else if (hit_i.c98) begin fire_o = 1'b1; op_o = OP_QUERY; end
              else if (hit_i.c88) begin fire_o = 1'b1; op_o = OP_SECID; end
              else if (hit_i.f0)  begin fire_o = 1'b1; op_o = OP_EXIT;  end
            end
          end
          S_PROG: begin
            if (!locked_i && !(suspended_i && in_region_i)) begin
              fire_o  = 1'b1;
              op_o    = OP_PROG;
              taddr_o = addr_i;
              tdata_o = data_i;
            end
          end
          S_E3: if (hit_i.at_a && hit_i.aa) state_d = S_E4;
          S_E4: if (hit_i.at_b && hit_i.k55) state_d = S_E5;
          S_E5: begin
            if (hit_i.at_a && hit_i.c10) begin
              if (wp_ni) begin
                fire_o = 1'b1;
                op_o   = OP_CHIP;
              end
            end else if (hit_i.c30) begin
              if (!locked_i) begin
                fire_o  = 1'b1;
                op_o    = OP_SEC;
                taddr_o = sec_addr;
              end
            end else if (hit_i.c50) begin
              if (!locked_i) begin
                fire_o  = 1'b1;
                op_o    = OP_BLK;
                taddr_o = blk_addr;
              end
            end
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int SEC_LSB  = 11,
  parameter int BLK_LSB  = 15,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [15:0]       cmd_data_o,
  output logic [1:0]        mode_o
);
  hit_t              hit;
  logic              locked, erase_run, suspended, in_region, fire;
  op_e               op;
  logic [ADDR_W-1:0] taddr;
  logic [15:0]       tdata;
  mode_e             mode_q;

  flash_cmd_match u_match (
    .key_addr_i (wr_addr_i[KEY_AW-1:0]),
    .key_data_i (wr_data_i[7:0]),
    .hit_o      (hit)
  );

  flash_boot_guard #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BOOT_TOP(BOOT_TOP)) u_guard (
    .blk_hi_i (wr_addr_i[ADDR_W-1:BLK_LSB]),
    .wp_ni    (wp_ni),
    .locked_o (locked)
  );

  flash_erase_susp #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .BLK_LSB(BLK_LSB)) u_susp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .op_i        (op),
    .ev_hi_i     (taddr[ADDR_W-1:SEC_LSB]),
    .probe_hi_i  (wr_addr_i[ADDR_W-1:SEC_LSB]),
    .erase_run_o (erase_run),
    .suspended_o (suspended),
    .in_region_o (in_region)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .BLK_LSB(BLK_LSB)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .addr_i      (wr_addr_i),
    .data_i      (wr_data_i),
    .busy_i      (busy_i),
    .wp_ni       (wp_ni),
    .hit_i       (hit),
    .locked_i    (locked),
    .erase_run_i (erase_run),
    .suspended_i (suspended),
    .in_region_i (in_region),
    .fire_o      (fire),
    .op_o        (op),
    .taddr_o     (taddr),
    .tdata_o     (tdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= 4'(OP_NONE);
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
      mode_q      <= MODE_READ;
    end else begin
      cmd_valid_o <= fire;
      cmd_op_o    <= fire ? 4'(op) : 4'(OP_NONE);
      cmd_addr_o  <= fire ? taddr : '0;
      cmd_data_o  <= fire ? tdata : '0;
      if (fire) begin
        case (op)
          OP_ID:    mode_q <= MODE_ID;
          OP_QUERY: mode_q <= MODE_QUERY;
          OP_SECID: mode_q <= MODE_SECID;
          OP_EXIT:  mode_q <= MODE_READ;
          default:  ;
        endcase
      end
    end
  end

  assign mode_o = 2'(mode_q);
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int SEC_LSB = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              busy_i,
  input logic              wp_ni,
  input logic              cmd_valid_o,
  input logic [3:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [1:0]        mode_o
);
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(wr_valid_i)); // R3

  AST_BUSY_ONLY_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && $past(busy_i)) |-> (cmd_op_o == 4'(OP_SUSP))); // R7

  AST_WP_NO_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !$past(wp_ni)) |-> (cmd_op_o != 4'(OP_CHIP))); // R10

  AST_SECTOR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 4'(OP_SEC)) |-> (cmd_addr_o[SEC_LSB-1:0] == '0)); // R4

  AST_CHIP_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 4'(OP_CHIP)) |-> (cmd_addr_o == '0)); // R4

  AST_ID_MODE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 4'(OP_ID)) |-> (mode_o == 2'(MODE_ID))); // R5

  AST_EXIT_TO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 4'(OP_EXIT)) |-> (mode_o == 2'(MODE_READ))); // R5
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .busy_i      (busy_i),
  .wp_ni       (wp_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_addr_o  (cmd_addr_o),
  .mode_o      (mode_o)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int AW = 21;
  localparam logic [3:0] P_NONE = 4'd0, P_PROG = 4'd1, P_SEC = 4'd2, P_BLK = 4'd3,
                         P_CHIP = 4'd4, P_ID = 4'd5, P_QRY = 4'd6, P_SID = 4'd7,
                         P_EXIT = 4'd8, P_SUSP = 4'd9, P_RES = 4'd10;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [15:0]   d;
    logic          v;
    logic [3:0]    op;
    logic [AW-1:0] ea;
    logic [15:0]   ed;
    logic [1:0]    m;
  } vec_t;

  localparam int NV = 54;
  localparam vec_t VEC [NV] = '{
    // R3 program
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00A0, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h012345, 16'hBEEF, 1'b1, P_PROG, 21'h012345, 16'hBEEF, 2'd0},
    // R2 upper address and data bits ignored
    '{21'h1F5555, 16'hFFAA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h01AAAA, 16'hAB55, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h015555, 16'h12A0, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h0F0000, 16'h0001, 1'b1, P_PROG, 21'h0F0000, 16'h0001, 2'd0},
    // R4 sector erase
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0080, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h0ABCDE, 16'h0030, 1'b1, P_SEC, 21'h0AB800, 16'h0, 2'd0},
    // R4 block erase
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0080, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h1F1234, 16'h0050, 1'b1, P_BLK, 21'h1F0000, 16'h0, 2'd0},
    // R4 chip erase
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0080, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0010, 1'b1, P_CHIP, 21'h0, 16'h0, 2'd0},
    // R5 ID entry, single-write exit
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0090, 1'b1, P_ID, 21'h0, 16'h0, 2'd1},
    '{21'h000123, 16'h00F0, 1'b1, P_EXIT, 21'h0, 16'h0, 2'd0},
    // R5 query entry, three-write exit
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0098, 1'b1, P_QRY, 21'h0, 16'h0, 2'd2},
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd2},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd2},
    '{21'h005555, 16'h00F0, 1'b1, P_EXIT, 21'h0, 16'h0, 2'd0},
    // R5 security-ID entry
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0088, 1'b1, P_SID, 21'h0, 16'h0, 2'd3},
    '{21'h007777, 16'h00F0, 1'b1, P_EXIT, 21'h0, 16'h0, 2'd0},
    // R6 aborts
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0054, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00A0, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h001234, 16'h0000, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0080, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAB, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0010, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h00AA, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h002AAA, 16'h0055, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h005555, 16'h0077, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0},
    '{21'h004444, 16'h0001, 1'b0, P_NONE, 21'h0, 16'h0, 2'd0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_valid_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [15:0]   wr_data_i = '0;
  logic          busy_i = 1'b0;
  logic          wp_ni = 1'b1;
  logic          cmd_valid_o;
  logic [3:0]    cmd_op_o;
  logic [AW-1:0] cmd_addr_o;
  logic [15:0]   cmd_data_o;
  logic [1:0]    mode_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  flash_cmd_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .busy_i(busy_i), .wp_ni(wp_ni), .cmd_valid_o(cmd_valid_o),
    .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o), .mode_o(mode_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one write at a falling edge, sample outputs at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_valid_i = 1'b1;
    wr_addr_i  = a;
    wr_data_i  = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic expect_cmd(input string tag, input logic v, input logic [3:0] op,
                            input logic [AW-1:0] a, input logic [15:0] d);
    check({tag, " valid"}, 64'(cmd_valid_o), 64'(v));
    if (v) begin
      check({tag, " op"}, 64'(cmd_op_o), 64'(op));
      check({tag, " addr"}, 64'(cmd_addr_o), 64'(a));
      check({tag, " data"}, 64'(cmd_data_o), 64'(d));
    end
  endtask

  task automatic unlock();
    wr(21'h005555, 16'h00AA);
    wr(21'h002AAA, 16'h0055);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    unlock();
    wr(21'h005555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(21'h005555, 16'h0080);
    unlock();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 valid", 64'(cmd_valid_o), 64'd0);
    check("R1 op", 64'(cmd_op_o), 64'd0);
    check("R1 addr", 64'(cmd_addr_o), 64'd0);
    check("R1 mode", 64'(mode_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after release", 64'(cmd_valid_o), 64'd0);

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("table row %0d", i);
      wr(VEC[i].a, VEC[i].d);
      expect_cmd(tag, VEC[i].v, VEC[i].op, VEC[i].ea, VEC[i].ed);
      check({tag, " mode"}, 64'(mode_o), 64'(VEC[i].m));
    end

    // R3 pulse lasts one clock
    prog(21'h000777, 16'h5A5A);
    expect_cmd("R3 pulse", 1'b1, P_PROG, 21'h000777, 16'h5A5A);
    @(negedge clk_i);
    check("R3 one clock", 64'(cmd_valid_o), 64'd0);

    // R7 busy: full sequence ignored
    busy_i = 1'b1;
    prog(21'h002000, 16'h1111);
    expect_cmd("R7 busy program", 1'b0, P_NONE, '0, '0);
    busy_i = 1'b0;
    // R7 busy mid-sequence holds the step
    unlock();
    busy_i = 1'b1;
    wr(21'h003333, 16'h0000);
    busy_i = 1'b0;
    wr(21'h005555, 16'h00A0);
    wr(21'h004321, 16'hCAFE);
    expect_cmd("R7 step held", 1'b1, P_PROG, 21'h004321, 16'hCAFE);
    // R7 exit ignored while busy
    unlock();
    wr(21'h005555, 16'h0090);
    busy_i = 1'b1;
    wr(21'h000000, 16'h00F0);
    expect_cmd("R7 exit while busy", 1'b0, P_NONE, '0, '0);
    check("R7 mode kept", 64'(mode_o), 64'd1);
    busy_i = 1'b0;
    wr(21'h000000, 16'h00F0);
    check("R7 exit after busy", 64'(mode_o), 64'd0);

    // R8 suspend and resume of a sector erase
    wr(21'h000000, 16'h00B0);
    expect_cmd("R8 suspend when idle", 1'b0, P_NONE, '0, '0);
    erase_prefix();
    wr(21'h0A0400, 16'h0030);
    expect_cmd("R8 sector erase", 1'b1, P_SEC, 21'h0A0000, 16'h0);
    busy_i = 1'b1;
    wr(21'h000000, 16'h00B0);
    expect_cmd("R8 suspend", 1'b1, P_SUSP, 21'h0, 16'h0);
    busy_i = 1'b0;
    // R9 program into the suspended sector refused, elsewhere accepted
    prog(21'h0A0123, 16'h2222);
    expect_cmd("R9 program suspended sector", 1'b0, P_NONE, '0, '0);
    prog(21'h0A0800, 16'h3333);
    expect_cmd("R9 program other sector", 1'b1, P_PROG, 21'h0A0800, 16'h3333);
    erase_prefix();
    wr(21'h0C0000, 16'h0030);
    expect_cmd("R9 erase during suspend", 1'b0, P_NONE, '0, '0);
    wr(21'h000000, 16'h0030);
    expect_cmd("R8 resume", 1'b1, P_RES, 21'h0, 16'h0);
    busy_i = 1'b1;
    wr(21'h000000, 16'h00B0);
    expect_cmd("R8 second suspend", 1'b1, P_SUSP, 21'h0, 16'h0);
    busy_i = 1'b0;
    wr(21'h000000, 16'h0030);
    expect_cmd("R8 second resume", 1'b1, P_RES, 21'h0, 16'h0);
    prog(21'h000100, 16'h4444);
    expect_cmd("R8 program after erase", 1'b1, P_PROG, 21'h000100, 16'h4444);
    busy_i = 1'b1;
    wr(21'h000000, 16'h00B0);
    expect_cmd("R8 suspend during program", 1'b0, P_NONE, '0, '0);
    busy_i = 1'b0;
    wr(21'h000000, 16'h0030);
    expect_cmd("R8 resume without suspend", 1'b0, P_NONE, '0, '0);

    // R10 write protect on the bottom boot block
    wp_ni = 1'b0;
    prog(21'h001000, 16'h5555);
    expect_cmd("R10 program boot", 1'b0, P_NONE, '0, '0);
    prog(21'h010000, 16'h6666);
    expect_cmd("R10 program outside boot", 1'b1, P_PROG, 21'h010000, 16'h6666);
    erase_prefix();
    wr(21'h004000, 16'h0030);
    expect_cmd("R10 sector erase boot", 1'b0, P_NONE, '0, '0);
    erase_prefix();
    wr(21'h100000, 16'h0050);
    expect_cmd("R10 block erase outside", 1'b1, P_BLK, 21'h100000, 16'h0);
    erase_prefix();
    wr(21'h005555, 16'h0010);
    expect_cmd("R10 chip erase", 1'b0, P_NONE, '0, '0);
    wp_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule